// File: doc/BRIEF.md
# Serial-In Latched Open-Drain Output Driver

This block accepts a serial bit stream paced by an external shift clock, collects it in a twelve-stage shift chain, and moves the collected word into a storage stage that drives twelve open-drain style outputs. A system that needs to set many load lines from only a few wires clocks a full word in, most significant bit first, then raises the latch input to update every output at once. A serial cascade output presents the last stage of the chain, so several blocks can be chained end to end.

The shift clock, serial data and latch inputs are treated as slow, asynchronous levels. A synchronizer on the system clock samples them, and edge detection turns them into single-cycle events. The storage stage is level-controlled: it follows the chain for as long as the latch input stays high. Each output pin is pulled low when its stored bit is 0 and released to high impedance when its stored bit is 1. A separate vector reports which output transistors are on. Raising the active-low enable releases every pin. The cascade output never depends on the enable.

All interfaces are plain level pins. Nothing in the block applies back-pressure. The sender must keep each shift clock level and each data level steady for at least `SYNC_STAGES + 2` system clock cycles.

Top module: `serlatch_od_drv`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, the shift chain, the storage stage and the cascade register all clear to 0. With `oe_n` low, every bit of `fet_on` is then 1 and `cas_out` is 0.
- R2: On each synchronized rising edge of `shift_clk`, stage 0 takes the level of `ser_in` and stage i takes the old value of stage i-1. After twelve shifts, stage i holds the bit that was sent in position i of a word sent MSB first.
- R3: While `latch_in` is low, shifting leaves `fet_on` and `od_pad` unchanged.
- R4: While `latch_in` is high, the storage stage follows the shift chain, including shifts made during that time. While `latch_in` is low, the storage stage keeps its value.
- R5: While `oe_n` is high, every bit of `fet_on` is 0 and every `od_pad` bit is released (z).
- R6: While `oe_n` is low, `fet_on[i]` is 1 exactly when stored bit i is 0. `od_pad[i]` drives 0 when `fet_on[i]` is 1 and is z otherwise.
- R7: `cas_out` shows the last chain stage and changes only on a synchronized falling edge of `shift_clk`. After a rising edge it keeps its previous value until the next falling edge.
- R8: `cas_out` keeps shifting and updating while `oe_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data level |
| shift_clk | input | 1 | Shift clock; a rising edge shifts, a falling edge updates the cascade |
| latch_in | input | 1 | Storage stage follows the chain while high |
| oe_n | input | 1 | Active-low output enable |
| od_pad | output | N_OUT | Open-drain pins: 0 when the transistor is on, z when it is off |
| fet_on | output | N_OUT | Transistor-on vector, one bit per pin |
| cas_out | output | 1 | Serial cascade output, last chain stage |

## Verification
A corrupted chain stage stays hidden until it reaches the ports. It shows at `cas_out` after the falling edge that follows its arrival at the last stage, or at `fet_on` within `SYNC_STAGES + 2` system cycles once the latch opens. A storage stage that has lost its hold shows up at once as a change of `fet_on` during shifting with the latch low. A wrong gating decision on the enable shows on the very next sample of the outputs. The bench therefore checks the outputs after every shift clock half period and around every latch and enable transition.

// File: rtl/serlatch_pkg.sv
package serlatch_pkg;
  // synchronized control bundle carried through the input synchronizer
  typedef struct packed {
    logic sclk;
    logic din;
    logic lat;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/serlatch_sync.sv
module serlatch_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/serlatch_edge.sv
module serlatch_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/serlatch_chain.sv
module serlatch_chain #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic         fall,
  input  logic         din,
  output logic [N-1:0] chain,
  output logic         cas
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      cas   <= 1'b0;
    end else begin
      if (rise) chain <= {chain[N-2:0], din};
      if (fall) cas   <= chain[N-1];
    end
  end
endmodule

// File: rtl/serlatch_store.sv
module serlatch_store #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lat,
  input  logic [N-1:0] chain,
  output logic [N-1:0] store
);
  always_ff @(posedge clk) begin
    if (!rst_n)   store <= '0;
    else if (lat) store <= chain;
  end
endmodule

// File: rtl/serlatch_drive.sv
module serlatch_drive #(
  parameter int N = 12
) (
  input  logic         oe_n,
  input  logic [N-1:0] store,
  output logic [N-1:0] fet_on,
  output wire  [N-1:0] pad
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      assign fet_on[i] = ~oe_n & ~store[i];
      assign pad[i]    = fet_on[i] ? 1'b0 : 1'bz;
    end
  endgenerate
endmodule

// File: rtl/serlatch_od_drv.sv
module serlatch_od_drv
  import serlatch_pkg::*;
#(
  parameter int N_OUT       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             latch_in,
  input  logic             oe_n,
  output wire  [N_OUT-1:0] od_pad,
  output logic [N_OUT-1:0] fet_on,
  output logic             cas_out
);
  ctl_t             ctl_raw;
  ctl_t             ctl_s;
  logic             sh_rise;
  logic             sh_fall;
  logic [N_OUT-1:0] chain_q;
  logic [N_OUT-1:0] store_q;

  assign ctl_raw = '{sclk: shift_clk, din: ser_in, lat: latch_in};

  serlatch_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  serlatch_edge edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(ctl_s.sclk), .rise(sh_rise), .fall(sh_fall)
  );

  serlatch_chain #(.N(N_OUT)) chain_i (
    .clk(clk), .rst_n(rst_n), .rise(sh_rise), .fall(sh_fall),
    .din(ctl_s.din), .chain(chain_q), .cas(cas_out)
  );

  serlatch_store #(.N(N_OUT)) store_i (
    .clk(clk), .rst_n(rst_n), .lat(ctl_s.lat), .chain(chain_q), .store(store_q)
  );

  serlatch_drive #(.N(N_OUT)) drive_i (
    .oe_n(oe_n), .store(store_q), .fet_on(fet_on), .pad(od_pad)
  );
endmodule

// File: rtl/serlatch_od_chk.sv
module serlatch_od_chk #(
  parameter int N = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         oe_n,
  input logic         rise,
  input logic         fall,
  input logic         lat,
  input logic [N-1:0] chain,
  input logic [N-1:0] store,
  input logic [N-1:0] fet_on,
  input logic         cas
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (store == '0 && chain == '0 && cas == 1'b0)); // R1

  AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(chain)); // R2

  AST_HOLD_WHEN_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    !lat |=> $stable(store)); // R4

  AST_FOLLOW_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    lat |=> (store == $past(chain))); // R4

  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (fet_on == '0)); // R5

  AST_ON_MATCHES_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> ((fet_on & store) == '0 && (fet_on | store) == {N{1'b1}})); // R6

  AST_CAS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(cas)); // R7
endmodule

bind serlatch_od_drv serlatch_od_chk #(.N(N_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .rise(sh_rise), .fall(sh_fall),
  .lat(ctl_s.lat), .chain(chain_q), .store(store_q), .fet_on(fet_on),
  .cas(cas_out)
);

// File: tb/serlatch_od_drv_tb.sv
module serlatch_od_drv_tb_top;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic shift_clk = 1'b0;
  logic latch_in = 1'b0;
  logic oe_n = 1'b0;
  wire  [N-1:0] od_pad;
  logic [N-1:0] fet_on;
  logic cas_out;

  always #2.5 clk = ~clk;

  serlatch_od_drv #(.N_OUT(N), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
    .latch_in(latch_in), .oe_n(oe_n), .od_pad(od_pad), .fet_on(fet_on),
    .cas_out(cas_out)
  );

  typedef struct {
    logic [N-1:0] on;
    logic         cas;
    string        req_on;
    string        req_cas;
  } item_t;

  item_t exp_q[$];
  event  sample_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // bench model
  logic [N-1:0] chain_m = '0;
  logic [N-1:0] store_m = '0;
  logic         cas_m = 1'b0;
  logic         lat_m = 1'b0;
  logic         oe_m = 1'b0;

  task automatic settle();
    repeat (8) @(posedge clk);
  endtask

  task automatic push(string r_on, string r_cas);
    item_t it;
    it.on = oe_m ? '0 : ~store_m;
    it.cas = cas_m;
    it.req_on = r_on;
    it.req_cas = r_cas;
    exp_q.push_back(it);
    ->sample_ev;
    repeat (3) @(posedge clk);
  endtask

  task automatic sh_rise(logic d, string r_on);
    @(negedge clk) ser_in = d;
    repeat (2) @(posedge clk);
    @(negedge clk) shift_clk = 1'b1;
    settle();
    chain_m = {chain_m[N-2:0], d};
    if (lat_m) store_m = chain_m;
    push(r_on, "R7");
  endtask

  task automatic sh_fall(string r_cas);
    @(negedge clk) shift_clk = 1'b0;
    settle();
    cas_m = chain_m[N-1];
    push("R3", r_cas);
  endtask

  task automatic load(logic [N-1:0] pat, string r_on, string r_cas);
    for (int i = N - 1; i >= 0; i--) begin
      sh_rise(pat[i], r_on);
      sh_fall(r_cas);
    end
  endtask

  task automatic set_latch(logic v, string r_on);
    @(negedge clk) latch_in = v;
    settle();
    lat_m = v;
    if (v) store_m = chain_m;
    push(r_on, "R7");
  endtask

  task automatic set_oe(logic v, string r_on);
    @(negedge clk) oe_n = v;
    settle();
    oe_m = v;
    push(r_on, "R8");
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chain_m = '0; store_m = '0; cas_m = 1'b0;
    settle();
    push("R1", "R1");
  endtask

  // monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      @(sample_ev);
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        n_chk++;
        if (fet_on !== it.on) begin
          n_fail++;
          $display("FAIL %s fet_on actual=%h expected=%h", it.req_on, fet_on, it.on);
        end
        n_chk++;
        if (cas_out !== it.cas) begin
          n_fail++;
          $display("FAIL %s cas_out actual=%b expected=%b", it.req_cas, cas_out, it.cas);
        end
        for (int i = 0; i < N; i++) begin
          if (it.on[i]) begin
            n_chk++;
            if (od_pad[i] !== 1'b0) begin
              n_fail++;
              $display("FAIL R6 od_pad[%0d] actual=%b expected=0", i, od_pad[i]);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    do_reset();                       // R1: all transistors on, cascade 0
    load(12'hA5C, "R3", "R7");        // R3 outputs hold, R7 half-clock lag
    set_latch(1'b1, "R2");            // R2 word arrives in order
    set_latch(1'b0, "R4");
    load(12'h3F0, "R3", "R7");        // R3 old word still shown
    set_oe(1'b1, "R5");               // R5 all released
    load(12'h0F3, "R5", "R8");        // R8 cascade runs with enable high
    set_latch(1'b1, "R5");
    set_latch(1'b0, "R5");
    set_oe(1'b0, "R6");               // R6 stored word shown
    set_latch(1'b1, "R4");            // R4 transparent
    sh_rise(1'b1, "R4");
    sh_fall("R7");
    sh_rise(1'b0, "R4");
    sh_fall("R7");
    set_latch(1'b0, "R4");
    sh_rise(1'b0, "R3");
    sh_fall("R7");
    do_reset();                       // R1 mid-run
    load(12'hFFF, "R3", "R7");
    set_latch(1'b1, "R6");            // R6 all off
    set_latch(1'b0, "R6");
    load(12'h000, "R3", "R7");
    set_latch(1'b1, "R6");            // R6 all on
    set_latch(1'b0, "R4");
    repeat (5) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule